// File: doc/BRIEF.md
# Nonvolatile Code Load and Program Controller

This block manages a 7-bit calibration code. The code lives in two places: a volatile register that drives the analog output, and a simple parallel nonvolatile store. The block keeps the two consistent. When reset is released it copies the stored code into the register. When a conditioned write-protect input falls, it copies the stored code into the register again. When the serial-bus side asks for a new code to be made permanent, it runs a long, fixed-length write cycle into the store.

The write-protect input is active low. It is passed through a synchronizer and a debounce filter before any level or edge is used. Its conditioned level starts as "protected" after reset, which is the same as an input left floating. A program request is accepted only when the controller is idle and the conditioned level is high. During the write cycle the controller stays busy for the whole programmed duration. At the end it loads the new code into the register. A write-protect fall that arrives mid-cycle is remembered and served as soon as the cycle ends.

Top module: `nvcode_ctrl`

## Requirements
- R1: While reset is held, `busy` is 1 and `nv_we` and `reg_load` are 0. One cycle after reset is released, `reg_load` pulses once with `reg_value` equal to `nv_rdata`, and `busy` drops in that same cycle.
- R2: When the conditioned write-protect level falls while the controller is idle, `reg_load` pulses exactly once with `reg_value` equal to the stored code. A rise of that level produces no load.
- R3: A one-cycle `prog_req` is accepted when the controller is idle and the conditioned write-protect level is 1. After acceptance, `nv_we` is high for exactly `PROG_CYCLES` consecutive cycles, `nv_wdata` carries the requested code, and `busy` is high for those same cycles.
- R4: In the cycle after `nv_we` drops, `reg_load` pulses with `reg_value` equal to the programmed code. A later read of the store returns that same code.
- R5: A `prog_req` that arrives while the conditioned write-protect level is 0 is dropped: `nv_we` stays 0 and the store is unchanged.
- R6: The conditioned level resets to 0 (protected). A request made right after reset is refused even if the raw input is already high. Requests are accepted only after the raw input has stayed high through `SYNC_STAGES` plus `DEB_CYCLES` cycles.
- R7: A raw write-protect low pulse shorter than `DEB_CYCLES` cycles causes no reload and does not stop later programming.
- R8: A `prog_req` that arrives while `busy` is high is ignored. It neither lengthens the cycle nor changes the code being written.
- R9: A conditioned write-protect fall during a write cycle does not stop the cycle. After the completion load, a second `reg_load` follows from the store, and `busy` stays high until it happens (`PROG_CYCLES`+1 cycles in total).
- R10: `nv_wdata` holds steady for every cycle in which `nv_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_raw | input | 1 | Raw active-low write-protect pin level (1 = programming allowed) |
| prog_req | input | 1 | One-cycle request to make `prog_code` permanent |
| prog_code | input | 7 | Code to be programmed |
| nv_rdata | input | 7 | Current contents of the nonvolatile store |
| nv_we | output | 1 | Store write enable, held for the whole write cycle |
| nv_wdata | output | 7 | Data presented to the store while `nv_we` is high |
| reg_load | output | 1 | One-cycle strobe that loads `reg_value` into the volatile register |
| reg_value | output | 7 | Code to load into the volatile register |
| busy | output | 1 | High during boot load, write cycle and any reload that follows it |

## Verification
The assertions assume the following about the inputs:
- Write-protect moves slowly.
- `prog_req` is a single-cycle pulse.
- The store presents written data on `nv_rdata` by the cycle after `nv_we` drops.

The stimulus keeps to these assumptions. It holds each write-protect level for longer than synchronizer plus debounce delay, except for the one deliberate short glitch. It raises requests for exactly one cycle. It models the store as a register that commits `nv_wdata` on each clock edge where `nv_we` is high. Every one of the 128 codes is programmed and checked against its own value, and the arithmetic lengths `PROG_CYCLES` and `PROG_CYCLES`+1 are checked for the plain and the deferred-reload cycles.

// File: rtl/nvcode_pkg.sv
package nvcode_pkg;

    // Width of the calibration code held in register and store.
    parameter int unsigned CODE_W = 7;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,   // copy store into register, then go idle
        ST_IDLE = 2'd1,   // wait for a request or a write-protect fall
        ST_PROG = 2'd2    // timed write cycle in progress
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e          state;
        logic                pend_reload;
        logic                nv_we;
        logic [CODE_W-1:0]   nv_wdata;
        logic                reg_load;
        logic [CODE_W-1:0]   reg_value;
        logic                busy;
    } ctl_regs_t;

endpackage

// File: rtl/nvcode_wp_cond.sv
module nvcode_wp_cond #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_CYCLES  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wp_raw,
    output logic wp_ok,
    output logic wp_fall
);

    localparam int unsigned DEB_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [DEB_W-1:0]       cnt;
        logic                   level;
        logic                   fall;
    } cond_t;

    cond_t cond_d, cond_q;
    logic  synced;

    assign synced = cond_q.sync[SYNC_STAGES-1];

    always_comb begin
        cond_d      = cond_q;
        cond_d.fall = 1'b0;
        if (SYNC_STAGES > 1) begin
            cond_d.sync = {cond_q.sync[SYNC_STAGES-2:0], wp_raw};
        end else begin
            cond_d.sync = {SYNC_STAGES{wp_raw}};
        end
        // Accept a new level only after it has differed for DEB_CYCLES cycles.
        if (synced != cond_q.level) begin
            if (cond_q.cnt == DEB_LAST) begin
                cond_d.level = synced;
                cond_d.cnt   = '0;
                cond_d.fall  = cond_q.level;
            end else begin
                cond_d.cnt = cond_q.cnt + 1'b1;
            end
        end else begin
            cond_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
        end else begin
            cond_q <= cond_d;
        end
    end

    assign wp_ok   = cond_q.level;
    assign wp_fall = cond_q.fall;

endmodule

// File: rtl/nvcode_timer.sv
module nvcode_timer #(
    parameter int unsigned CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CNT_LOAD;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = tmr_q.run && (tmr_q.cnt == '0);

endmodule

// File: rtl/nvcode_ctrl.sv
module nvcode_ctrl
    import nvcode_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 1000000,
    parameter int unsigned DEB_CYCLES  = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_raw,
    input  logic              prog_req,
    input  logic [CODE_W-1:0] prog_code,
    input  logic [CODE_W-1:0] nv_rdata,
    output logic              nv_we,
    output logic [CODE_W-1:0] nv_wdata,
    output logic              reg_load,
    output logic [CODE_W-1:0] reg_value,
    output logic              busy
);

    logic      wp_ok;
    logic      wp_fall;
    logic      tmr_start;
    logic      tmr_done;
    ctl_regs_t ctl_d, ctl_q;

    nvcode_wp_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .DEB_CYCLES  (DEB_CYCLES)
    ) u_wp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wp_raw  (wp_n_raw),
        .wp_ok   (wp_ok),
        .wp_fall (wp_fall)
    );

    nvcode_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.reg_load = 1'b0;
        tmr_start      = 1'b0;
        unique case (ctl_q.state)
            ST_LOAD: begin
                ctl_d.reg_load    = 1'b1;
                ctl_d.reg_value   = nv_rdata;
                ctl_d.busy        = 1'b0;
                ctl_d.pend_reload = 1'b0;
                ctl_d.state       = ST_IDLE;
            end
            ST_IDLE: begin
                if (wp_fall) begin
                    ctl_d.reg_load  = 1'b1;
                    ctl_d.reg_value = nv_rdata;
                end else if (prog_req && wp_ok) begin
                    ctl_d.state    = ST_PROG;
                    ctl_d.nv_we    = 1'b1;
                    ctl_d.nv_wdata = prog_code;
                    ctl_d.busy     = 1'b1;
                    tmr_start      = 1'b1;
                end
            end
            ST_PROG: begin
                if (wp_fall) begin
                    ctl_d.pend_reload = 1'b1;
                end
                if (tmr_done) begin
                    ctl_d.nv_we     = 1'b0;
                    ctl_d.reg_load  = 1'b1;
                    ctl_d.reg_value = ctl_q.nv_wdata;
                    if (ctl_q.pend_reload || wp_fall) begin
                        ctl_d.state = ST_LOAD;
                    end else begin
                        ctl_d.busy  = 1'b0;
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            default: begin
                ctl_d.state = ST_LOAD;
                ctl_d.busy  = 1'b1;
                ctl_d.nv_we = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_LOAD;
            ctl_q.busy  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign nv_we     = ctl_q.nv_we;
    assign nv_wdata  = ctl_q.nv_wdata;
    assign reg_load  = ctl_q.reg_load;
    assign reg_value = ctl_q.reg_value;
    assign busy      = ctl_q.busy;

endmodule

// File: rtl/nvcode_ctrl_chk.sv
module nvcode_ctrl_chk #(
    parameter int unsigned PROG_CYCLES = 1000000,
    parameter int unsigned CODE_W      = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_ok,
    input logic              prog_req,
    input logic              nv_we,
    input logic [CODE_W-1:0] nv_wdata,
    input logic              reg_load,
    input logic              busy
);

    // Length of the current run of write-enable cycles.
    logic [31:0] we_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run <= '0;
        end else if (nv_we) begin
            we_run <= we_run + 32'd1;
        end else begin
            we_run <= '0;
        end
    end

    p_we_inside_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> busy);

    p_cycle_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_we) |-> (we_run == 32'(PROG_CYCLES)));

    p_gated_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_we) |-> ($past(wp_ok) && $past(prog_req)));

    p_done_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_we) |-> reg_load);

    p_no_load_mid_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_load |-> !nv_we);

    p_idle_entry_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> reg_load);

    p_wdata_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_we && $past(nv_we)) |-> $stable(nv_wdata));

endmodule

bind nvcode_ctrl nvcode_ctrl_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .CODE_W      (nvcode_pkg::CODE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_ok    (wp_ok),
    .prog_req (prog_req),
    .nv_we    (nv_we),
    .nv_wdata (nv_wdata),
    .reg_load (reg_load),
    .busy     (busy)
);

// File: tb/nvcode_ctrl_test.sv
`timescale 1ns/1ps
module nvcode_ctrl_test;

    localparam int PROG = 50;
    localparam int DEB  = 4;
    localparam int SYNC = 2;
    localparam int SETTLE = SYNC + DEB + 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wp_n_raw;
    logic       prog_req;
    logic [6:0] prog_code;
    logic [6:0] mem;
    logic       nv_we;
    logic [6:0] nv_wdata;
    logic       reg_load;
    logic [6:0] reg_value;
    logic       busy;

    logic       poke_en;
    logic [6:0] poke_val;
    logic [6:0] boot_val;

    int checks = 0;
    int errors = 0;
    int loads = 0;
    int we_cur = 0, we_len = 0, we_total = 0, we_glitch = 0;
    int busy_cur = 0, busy_len = 0;
    logic [6:0] last_load = '0;
    logic [6:0] we_first = '0;

    always #5 clk = ~clk;

    nvcode_ctrl #(
        .PROG_CYCLES (PROG),
        .DEB_CYCLES  (DEB),
        .SYNC_STAGES (SYNC)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_n_raw  (wp_n_raw),
        .prog_req  (prog_req),
        .prog_code (prog_code),
        .nv_rdata  (mem),
        .nv_we     (nv_we),
        .nv_wdata  (nv_wdata),
        .reg_load  (reg_load),
        .reg_value (reg_value),
        .busy      (busy)
    );

    // Storage model: commits on each edge with write enable high.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem <= boot_val;
        else if (nv_we)   mem <= nv_wdata;
        else if (poke_en) mem <= poke_val;
    end

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_load) begin
                loads++;
                last_load = reg_value;
            end
            if (nv_we) begin
                if (we_cur == 0) we_first = nv_wdata;
                else if (nv_wdata != we_first) we_glitch++;
                we_cur++;
                we_total++;
            end else if (we_cur != 0) begin
                we_len = we_cur;
                we_cur = 0;
            end
            if (busy) busy_cur++;
            else if (busy_cur != 0) begin
                busy_len = busy_cur;
                busy_cur = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input logic [6:0] code);
        prog_req  = 1'b1;
        prog_code = code;
        tick(1);
        prog_req  = 1'b0;
    endtask

    task automatic poke(input logic [6:0] v);
        poke_en  = 1'b1;
        poke_val = v;
        tick(1);
        poke_en  = 1'b0;
    endtask

    task automatic wait_idle();
        tick(1);
        while (busy) tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int l0;
        int wt0;
        rst_n     = 1'b0;
        wp_n_raw  = 1'b1;
        prog_req  = 1'b0;
        prog_code = '0;
        poke_en   = 1'b0;
        poke_val  = '0;
        boot_val  = 7'h2A;
        tick(3);
        // R1: reset state
        chk("R1 busy in reset", busy, 1);
        chk("R1 we in reset", nv_we, 0);
        chk("R1 load in reset", reg_load, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 boot load strobe", reg_load, 1);
        chk("R1 boot load value", reg_value, 7'h2A);
        chk("R1 busy after boot", busy, 0);

        // R6: conditioned level still protected right after reset
        request(7'd5);
        tick(PROG + 10);
        chk("R6 early request refused we", we_total, 0);
        chk("R6 early request store", mem, 7'h2A);
        request(7'd5);
        wait_idle();
        tick(1);
        chk("R6 request accepted later", mem, 5);

        // R3 R4 R10: exhaustive sweep over every code
        for (int c = 0; c < 128; c++) begin
            l0 = loads;
            request(7'(c));
            wait_idle();
            tick(1);
            chk("R4 store holds code", mem, c);
            chk("R4 completion load value", last_load, c);
            chk("R4 one load", loads, l0 + 1);
            chk("R3 write length", we_len, PROG);
            chk("R3 busy length", busy_len, PROG);
        end
        chk("R10 write data steady", we_glitch, 0);

        // R2: falling write-protect reloads stored code, rising does not
        foreach (boot_val[i]) begin end
        for (int k = 0; k < 3; k++) begin
            logic [6:0] v;
            v = (k == 0) ? 7'd0 : (k == 1) ? 7'd127 : 7'h55;
            poke(v);
            l0 = loads;
            wp_n_raw = 1'b0;
            tick(SETTLE);
            chk("R2 fall loads once", loads, l0 + 1);
            chk("R2 fall load value", last_load, v);
            wp_n_raw = 1'b1;
            tick(SETTLE);
            chk("R2 rise no load", loads, l0 + 1);
        end

        // R5: request while protected is dropped
        wp_n_raw = 1'b0;
        tick(SETTLE);
        wt0 = we_total;
        request(7'd9);
        tick(PROG + 10);
        chk("R5 no write enable", we_total, wt0);
        chk("R5 store unchanged", mem, 7'h55);
        wp_n_raw = 1'b1;
        tick(SETTLE);

        // R7: short glitch ignored
        l0 = loads;
        wp_n_raw = 1'b0;
        tick(2);
        wp_n_raw = 1'b1;
        tick(SETTLE);
        chk("R7 glitch no reload", loads, l0);
        request(7'd33);
        wait_idle();
        tick(1);
        chk("R7 programming still allowed", mem, 33);

        // R8: request during busy ignored
        l0 = loads;
        request(7'd10);
        tick(5);
        request(7'd20);
        wait_idle();
        tick(1);
        chk("R8 store keeps first code", mem, 10);
        chk("R8 write length unchanged", we_len, PROG);
        chk("R8 single load", loads, l0 + 1);

        // R9: write-protect fall during a cycle defers a reload
        l0 = loads;
        request(7'd77);
        tick(10);
        wp_n_raw = 1'b0;
        wait_idle();
        tick(2);
        chk("R9 two loads", loads, l0 + 2);
        chk("R9 reload value", last_load, 77);
        chk("R9 store value", mem, 77);
        chk("R9 write length", we_len, PROG);
        chk("R9 busy length", busy_len, PROG + 1);
        wp_n_raw = 1'b1;
        tick(SETTLE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule